// File: doc/BRIEF.md
# Selectable PRBS Pattern Checker

This block watches a received serial stream, one bit per clock, and tells whether that stream follows one of four pseudo-random binary sequences. A two-bit pattern select picks the sequence while the block runs. The checker synchronises itself. Every accepted bit is shifted into a history register. The bit is then compared with the XOR of two earlier bits, at the tap distances of the selected polynomial. No seed has to be loaded.

When enough consecutive bits match, the checker declares lock. From then on it counts every mismatching bit in a saturating counter. Four level controls steer the block: an enable, the pattern select, an inversion of the incoming data, and a clear that holds the error count at zero. Any logic that deserialises, recovers the clock or holds the control word sits outside this block.

Top module: `prbs_chk`

## Requirements
- R1: `cfg_mode` selects the recurrence used for the prediction. Let b[k] be the k-th accepted bit after inversion. Code 0 predicts b[k-9]^b[k-5] (x^9+x^5+1, length 9). Code 1 predicts b[k-15]^b[k-14] (length 15). Code 2 predicts b[k-23]^b[k-18] (length 23). Code 3 predicts b[k-31]^b[k-28] (length 31). History bits not yet received count as 0.
- R2: When `cfg_invert` is 1, each received bit is complemented before it enters the history and before the comparison. When it is 0, the bit is used as received.
- R3: A bit is accepted only in a cycle where `rx_vld` is 1. Cycles with `rx_vld` at 0 leave the history, the lock state and the count unchanged.
- R4: A run of consecutive accepted matching bits equal to the selected length sets `locked`, one cycle after the last bit of the run. Once set, `locked` stays high through later mismatches until a flush.
- R5: An accepted mismatching bit adds one to `err_cnt`, one cycle later, only when `locked` was already 1 in the cycle that bit arrived. A mismatch while unlocked is not counted.
- R6: `err_cnt` is `CNT_W` bits wide (default 16). It stops at all ones and does not wrap.
- R7: While `cfg_cnt_clr` is 1, `err_cnt` reads 0 from the next cycle on. Counting resumes with the first bit accepted after the clear returns to 0.
- R8: When `cfg_en` is 0, the block clears the lock, the run and the history, and `err_cnt` keeps its value.
- R9: A change of `cfg_mode` clears the lock, the run and the history. The bit offered in the cycle of the change is discarded.
- R10: After reset, `err_cnt` is 0 and `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Checker enable; driven to 1 after reset |
| cfg_mode | input | 2 | Pattern select: 0 = 9, 1 = 15, 2 = 23, 3 = 31 |
| cfg_invert | input | 1 | Complement the incoming bit when 1 |
| cfg_cnt_clr | input | 1 | Holds the error count at zero while 1 |
| rx_bit | input | 1 | Received data bit |
| rx_vld | input | 1 | Qualifies `rx_bit` |
| err_cnt | output | CNT_W | Saturating count of errors seen while locked |
| locked | output | 1 | Lock indication |

## Verification
Every result of this block shows up exactly one clock edge after the cycle of its cause. This holds for a counted error, a newly declared lock, a clear, and a flush from disable or a mode change, because each passes through a single register stage. The bench drives each stimulus on a falling edge. At the same moment it updates a behavioural model written from the recurrences above and queues the expected `locked` and `err_cnt`. A monitor pops that entry 1 ns after the following rising edge and compares it. Targeted checks at the end of each phase sample at that same point.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int HIST_W = 31;
    localparam int RUN_W  = $clog2(HIST_W + 1);

    typedef enum logic [1:0] {
        PAT_P9  = 2'd0,
        PAT_P15 = 2'd1,
        PAT_P23 = 2'd2,
        PAT_P31 = 2'd3
    } pat_e;

    typedef logic [RUN_W-1:0] run_t;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_st_t;

    typedef struct packed {
        run_t run;
        logic locked;
    } lock_st_t;

    typedef struct packed {
        pat_e mode;
    } ctl_st_t;

    function automatic run_t pat_len(pat_e p);
        run_t len;
        case (p)
            PAT_P9:  len = run_t'(9);
            PAT_P15: len = run_t'(15);
            PAT_P23: len = run_t'(23);
            default: len = run_t'(31);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/prbs_chk_hist.sv
module prbs_chk_hist
    import prbs_chk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pat_e pat_i,
    input  logic flush_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic mismatch_o
);

    hist_st_t st_q, st_d;
    logic     pred;

    always_comb begin
        case (pat_i)
            PAT_P9:  pred = st_q.hist[8]  ^ st_q.hist[4];
            PAT_P15: pred = st_q.hist[14] ^ st_q.hist[13];
            PAT_P23: pred = st_q.hist[22] ^ st_q.hist[17];
            default: pred = st_q.hist[30] ^ st_q.hist[27];
        endcase
        mismatch_o = bit_i ^ pred;

        st_d = st_q;
        if (flush_i) begin
            st_d.hist = '0;
        end else if (shift_i) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8 / R9: a flush empties the history
    p_hist_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.hist == '0));

    // R3: without an accepted bit the history is frozen
    p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !shift_i) |=> $stable(st_q.hist));

endmodule

// File: rtl/prbs_chk_lock.sv
module prbs_chk_lock
    import prbs_chk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pat_e pat_i,
    input  logic flush_i,
    input  logic shift_i,
    input  logic mismatch_i,
    output logic locked_o
);

    lock_st_t st_q, st_d;
    run_t     len;

    always_comb begin
        len  = pat_len(pat_i);
        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else if (shift_i) begin
            if (mismatch_i) begin
                st_d.run = '0;
            end else if (st_q.run < len) begin
                st_d.run = st_q.run + 1'b1;
            end
            if (st_d.run == len) begin
                st_d.locked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;

    // R8 / R9: a flush always drops lock
    p_flush_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !locked_o);

    // R4: lock persists until a flush
    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !flush_i) |=> locked_o);

    // R4: lock can only be gained on an accepted matching bit
    p_lock_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && !(shift_i && !mismatch_i)) |=> !locked_o);

endmodule

// File: rtl/prbs_chk_errcnt.sv
module prbs_chk_errcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R7: clear forces zero on the next cycle
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    // R6: a full counter stays full
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_o == CNT_MAX) && !clr_i) |=> (cnt_o == CNT_MAX));

    // R5: no increment request, no change
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> (cnt_o == $past(cnt_o)));

    // R5: at most one step per cycle
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1)));

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_invert,
    input  logic             cfg_cnt_clr,
    input  logic             rx_bit,
    input  logic             rx_vld,
    output logic [CNT_W-1:0] err_cnt,
    output logic             locked
);

    ctl_st_t st_q, st_d;
    pat_e    pat_sel;
    logic    flush;
    logic    shift;
    logic    bit_n;
    logic    mismatch;
    logic    lock_w;
    logic    inc;

    assign pat_sel = pat_e'(cfg_mode);

    always_comb begin
        st_d      = st_q;
        st_d.mode = pat_sel;
        flush     = !cfg_en || (pat_sel != st_q.mode);
        shift     = rx_vld && !flush;
        bit_n     = rx_bit ^ cfg_invert;
        inc       = shift && lock_w && mismatch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PAT_P9};
        end else begin
            st_q <= st_d;
        end
    end

    prbs_chk_hist i_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_i      (pat_sel),
        .flush_i    (flush),
        .shift_i    (shift),
        .bit_i      (bit_n),
        .mismatch_o (mismatch)
    );

    prbs_chk_lock i_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_i      (pat_sel),
        .flush_i    (flush),
        .shift_i    (shift),
        .mismatch_i (mismatch),
        .locked_o   (lock_w)
    );

    prbs_chk_errcnt #(.CNT_W(CNT_W)) i_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (inc),
        .clr_i (cfg_cnt_clr),
        .cnt_o (err_cnt)
    );

    assign locked = lock_w;

    // R9: a pattern change drops lock on the next cycle
    p_mode_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel != st_q.mode) |=> !locked);

    // R8: disabled checker keeps its count
    p_dis_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !cfg_cnt_clr) |=> (err_cnt == $past(err_cnt)));

    // R3: an idle cycle changes no output
    p_idle_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_vld && cfg_en && (pat_sel == st_q.mode) && !cfg_cnt_clr)
        |=> ($stable(err_cnt) && $stable(locked)));

endmodule

// File: tb/test_prbs_chk.sv
`timescale 1ns/1ps
module test_prbs_chk;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b1;
    logic [1:0]       cfg_mode = 2'd0;
    logic             cfg_invert = 1'b0;
    logic             cfg_cnt_clr = 1'b0;
    logic             rx_bit = 1'b0;
    logic             rx_vld = 1'b0;
    logic [CNT_W-1:0] err_cnt;
    logic             locked;

    always #2 clk = ~clk;

    prbs_chk #(.CNT_W(CNT_W)) i_prbs_chk (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_invert(cfg_invert), .cfg_cnt_clr(cfg_cnt_clr),
        .rx_bit(rx_bit), .rx_vld(rx_vld), .err_cnt(err_cnt), .locked(locked)
    );

    typedef struct {
        logic             lk;
        logic [CNT_W-1:0] cnt;
        string            tag;
    } exp_t;

    exp_t  q[$];
    int    n_run = 0;
    int    n_fail = 0;
    string cur_tag = "none";

    // control values applied with the next step
    logic       c_en = 1'b1;
    logic [1:0] c_mode = 2'd0;
    logic       c_inv = 1'b0;
    logic       c_clr = 1'b0;

    // model state
    logic [30:0]      m_hist = '0;
    int               m_run = 0;
    logic             m_lock = 1'b0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic [1:0]       m_pmode = 2'd0;

    // pattern source
    logic [30:0] g_st = 31'h1234567;

    function automatic int tl(input logic [1:0] m);
        case (m)
            2'd0: return 9;
            2'd1: return 15;
            2'd2: return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int ts(input logic [1:0] m);
        case (m)
            2'd0: return 5;
            2'd1: return 14;
            2'd2: return 18;
            default: return 28;
        endcase
    endfunction

    task automatic step(input logic b, input logic v);
        logic bb, pred, e;
        int   ll, ss;
        @(negedge clk);
        cfg_en = c_en; cfg_mode = c_mode; cfg_invert = c_inv; cfg_cnt_clr = c_clr;
        rx_bit = b; rx_vld = v;
        ll = tl(c_mode); ss = ts(c_mode);
        if (!c_en || (c_mode != m_pmode)) begin
            m_hist = '0; m_run = 0; m_lock = 1'b0;
        end else if (v) begin
            bb   = b ^ c_inv;
            pred = m_hist[ll-1] ^ m_hist[ss-1];
            e    = (bb != pred);
            if (m_lock && e && (m_cnt != {CNT_W{1'b1}})) m_cnt = m_cnt + 1'b1;
            m_hist = {m_hist[29:0], bb};
            if (e) m_run = 0;
            else if (m_run < ll) m_run++;
            if (m_run == ll) m_lock = 1'b1;
        end
        if (c_clr) m_cnt = '0;
        m_pmode = c_mode;
        q.push_back('{lk: m_lock, cnt: m_cnt, tag: cur_tag});
    endtask

    task automatic gen(output logic b);
        int ll, ss;
        ll = tl(c_mode); ss = ts(c_mode);
        b = g_st[ll-1] ^ g_st[ss-1];
        g_st = {g_st[29:0], b};
    endtask

    // n pattern bits, optionally flipping every k-th, optionally complemented
    task automatic feed(input int n, input int k, input logic cpl);
        logic b;
        for (int i = 0; i < n; i++) begin
            gen(b);
            if ((k > 0) && ((i % k) == (k - 1))) b = ~b;
            step(b ^ cpl, 1'b1);
        end
    endtask

    // a bit that is certain to mismatch the current prediction
    task automatic bad_bit();
        int ll, ss;
        ll = tl(c_mode); ss = ts(c_mode);
        step(~(m_hist[ll-1] ^ m_hist[ss-1]) ^ c_inv, 1'b1);
    endtask

    task automatic check(input logic ok, input string msg, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic settle();
        step(1'b0, 1'b0);
        @(posedge clk);
        #1;
    endtask

    // scoreboard monitor
    always begin
        exp_t x;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            x = q.pop_front();
            n_run++;
            if ((locked !== x.lk) || (err_cnt !== x.cnt)) begin
                n_fail++;
                $display("FAIL %s: locked=%0b err_cnt=%0d expected locked=%0b err_cnt=%0d",
                         x.tag, locked, err_cnt, x.lk, x.cnt);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] saved;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(err_cnt == 0, "R10 reset count", int'(err_cnt), 0);
        check(locked == 1'b0, "R10 reset lock", int'(locked), 0);

        cur_tag = "R1 R4 PRBS9 clean";
        c_mode = 2'd0;
        feed(40, 0, 1'b0);
        settle();
        check(locked == 1'b1, "R4 lock PRBS9", int'(locked), 1);
        check(err_cnt == 0, "R5 no errors on clean data", int'(err_cnt), 0);

        cur_tag = "R5 errors while locked";
        feed(60, 10, 1'b0);
        settle();
        check(err_cnt != 0, "R5 flips counted", int'(err_cnt), -1);

        cur_tag = "R7 clear held";
        c_clr = 1'b1;
        feed(30, 7, 1'b0);
        settle();
        check(err_cnt == 0, "R7 count held at zero", int'(err_cnt), 0);
        c_clr = 1'b0;
        cur_tag = "R7 resume after clear";
        feed(30, 7, 1'b0);
        settle();
        check(err_cnt != 0, "R7 counting resumes", int'(err_cnt), -1);

        cur_tag = "R3 invalid bits ignored";
        saved = err_cnt;
        for (int i = 0; i < 12; i++) step(i[0], 1'b0);
        settle();
        check(err_cnt == saved, "R3 count unchanged", int'(err_cnt), int'(saved));
        check(locked == 1'b1, "R3 lock unchanged", int'(locked), 1);

        cur_tag = "R8 disabled";
        c_en = 1'b0;
        for (int i = 0; i < 10; i++) bad_bit();
        settle();
        check(locked == 1'b0, "R8 lock cleared", int'(locked), 0);
        check(err_cnt == saved, "R8 count held", int'(err_cnt), int'(saved));
        c_en = 1'b1;

        cur_tag = "R9 R2 PRBS15 complemented data, no inversion";
        c_mode = 2'd1;
        step(1'b1, 1'b1);
        check(1'b1, "R9 mode change step", 0, 0);
        feed(60, 0, 1'b1);
        settle();
        check(locked == 1'b0, "R2 complemented data never locks", int'(locked), 0);

        cur_tag = "R2 PRBS15 inversion on";
        c_inv = 1'b1;
        feed(60, 0, 1'b1);
        settle();
        check(locked == 1'b1, "R2 inverted input locks", int'(locked), 1);
        c_inv = 1'b0;

        cur_tag = "R1 R9 PRBS23 clean";
        c_mode = 2'd2;
        step(1'b0, 1'b1);
        @(posedge clk);
        #1;
        check(locked == 1'b0, "R9 lock dropped on mode change", int'(locked), 0);
        feed(80, 0, 1'b0);
        settle();
        check(locked == 1'b1, "R1 lock PRBS23", int'(locked), 1);

        cur_tag = "R1 PRBS31 clean";
        c_mode = 2'd3;
        feed(100, 0, 1'b0);
        settle();
        check(locked == 1'b1, "R1 lock PRBS31", int'(locked), 1);

        cur_tag = "R6 saturation";
        c_mode = 2'd0;
        c_clr = 1'b1;
        feed(40, 0, 1'b0);
        c_clr = 1'b0;
        for (int i = 0; i < 65540; i++) bad_bit();
        settle();
        check(err_cnt == {CNT_W{1'b1}}, "R6 saturated", int'(err_cnt), 65535);
        cur_tag = "R7 clear from full";
        c_clr = 1'b1;
        step(1'b0, 1'b0);
        settle();
        check(err_cnt == 0, "R7 clear from full", int'(err_cnt), 0);
        c_clr = 1'b0;

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule